// File: doc/BRIEF.md
# Fractional Bit-Clock Divider

This block derives a serial-port bit clock from a fast reference clock, for example a timer base of about 66.66 MHz. The output runs at a programmable fractional fraction of the reference. The divide ratio comes from three control fields. `div_int_i` is the whole part A. `frac_num_i` is a numerator term B. `frac_den_i` is a denominator term C. Every output period lasts either A or A+1 reference cycles. A phase accumulator picks between the two lengths, so the long-run average period equals the programmed ratio. The resulting jitter of one reference cycle is accepted because the average frequency is exact.

With `mode_plain_i` low, the average divisor is A + (B+1)/(C+1). With it high, the average divisor is A + B/(C+1). The output is a square-ish wave with a one-cycle strobe on each rising edge. Software or a neighbouring block may change the fields at any time. They take effect only at the next period boundary, so no partial period is ever produced. All pins are plain control or clock outputs. There is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `frac_bitclk_gen`

## Requirements
- R1: Every output period, measured from one `bclk_rise_o` pulse to the next, lasts either A_eff or A_eff+1 reference cycles, where A_eff is the sampled `div_int_i`.
- R2: With `mode_plain_i` = 0 and the field values held, any C+1 consecutive periods together last exactly (C+1)·A_eff + (B+1) reference cycles.
- R3: With `mode_plain_i` = 1 and the field values held, any C+1 consecutive periods together last exactly (C+1)·A_eff + B reference cycles.
- R4: If the numerator (B+1, or B when `mode_plain_i` = 1) is larger than C+1, it saturates to C+1, so that every period lasts A_eff+1 cycles.
- R5: Within a period of P cycles, `bclk_o` is high for the first floor(P/2) cycles and low for the remaining cycles.
- R6: `bclk_rise_o` is high for exactly one cycle per period: the first cycle of the period, which is also the first high cycle of `bclk_o`.
- R7: The fields and the mode are sampled only in the last cycle of a period. A change made in the middle of a period does not alter that period's length.
- R8: While `rst_ni` is low, both outputs are low and the accumulator is cleared. The first period begins, with `bclk_rise_o` high, in the cycle after the first rising clock edge at which `rst_ni` is high.
- R9: A `div_int_i` value below 2 is treated as 2, so A_eff = max(A, 2).
- R10: When the sampled C+1 differs from the value used for the previous period, the accumulator restarts from zero before the new numerator is added.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| div_int_i | input | A_W (10) | Whole part A of the divide ratio |
| frac_num_i | input | F_W (8) | Numerator term B |
| frac_den_i | input | F_W (8) | Denominator term C; the denominator is C+1 |
| mode_plain_i | input | 1 | 0: numerator is B+1; 1: numerator is B |
| bclk_o | output | 1 | Bit-clock output |
| bclk_rise_o | output | 1 | One-cycle strobe on each rising edge of `bclk_o` |

## Verification
The ratio is tried in both modes with the following patterns: zero fractions, a full fraction (numerator equal to denominator), a mid-range fraction, a large whole part, a saturating numerator, and a whole part below the minimum. Summing C+1 periods separates the B+1 and B numerator forms, and it exposes any lost or extra stretch. The waveform check uses odd and minimum period lengths, which tell floor from ceiling in the high time. Two cases change the fields mid-period: one changes A and the other changes C after the accumulator has built up. These show whether the fields are sampled only at the boundary and whether the accumulator restarts. A behavioural model is compared on every cycle throughout.

// File: rtl/fbc_pkg.sv
package fbc_pkg;
  // Smallest whole divisor that still leaves one high and one low cycle.
  localparam int unsigned FBC_MIN_DIV = 2;

  typedef enum logic {
    DIV_PLUS_ONE = 1'b0,   // numerator is B+1
    DIV_PLAIN    = 1'b1    // numerator is B
  } fbc_mode_e;
endpackage

// File: rtl/fbc_cfg_sample.sv
module fbc_cfg_sample
  import fbc_pkg::*;
#(
  parameter int A_W = 10,
  parameter int F_W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [A_W-1:0] a_i,
  input  logic [F_W-1:0] b_i,
  input  logic [F_W-1:0] c_i,
  input  logic           mode_i,
  output logic [A_W-1:0] eff_a_o,
  output logic [F_W:0]   num_o,
  output logic [F_W:0]   den_o,
  output logic           den_new_o,
  output logic [A_W-1:0] a_q_o
);
  logic [F_W:0] num_raw;
  logic [F_W:0] den_q;
  fbc_mode_e    mode;

  always_comb begin
    mode    = fbc_mode_e'(mode_i);
    den_o   = {1'b0, c_i} + (F_W+1)'(1);
    num_raw = (mode == DIV_PLAIN) ? {1'b0, b_i} : ({1'b0, b_i} + (F_W+1)'(1));
    // Saturate so the numerator never exceeds the denominator.
    num_o   = (num_raw > den_o) ? den_o : num_raw;
    eff_a_o = (a_i < A_W'(FBC_MIN_DIV)) ? A_W'(FBC_MIN_DIV) : a_i;
    den_new_o = (den_o != den_q);
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      den_q <= '0;
      a_q_o <= '0;
    end else if (load_i) begin
      den_q <= den_o;
      a_q_o <= eff_a_o;
    end
  end
endmodule

// File: rtl/fbc_phase_acc.sv
module fbc_phase_acc #(
  parameter int F_W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         clear_i,
  input  logic [F_W:0] num_i,
  input  logic [F_W:0] den_i,
  output logic         stretch_o
);
  localparam int S_W = F_W + 2;

  logic [F_W:0]   acc_q;
  logic [S_W-1:0] base;
  logic [S_W-1:0] sum;
  logic [S_W-1:0] rem;

  always_comb begin
    base      = clear_i ? '0 : {1'b0, acc_q};
    sum       = base + {1'b0, num_i};
    stretch_o = (sum >= {1'b0, den_i});
    rem       = stretch_o ? (sum - {1'b0, den_i}) : sum;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)     acc_q <= '0;
    else if (step_i) acc_q <= rem[F_W:0];
  end

  // R2 R3: the residue always stays below the denominator it was reduced by
  p_acc_below_den_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> (acc_q < $past(den_i)));
endmodule

// File: rtl/fbc_period_gen.sv
module fbc_period_gen #(
  parameter int LEN_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LEN_W-1:0] len_next_i,
  output logic             boundary_o,
  output logic [LEN_W-1:0] len_o,
  output logic             bclk_o,
  output logic             rise_o
);
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] half;

  always_comb begin
    half       = len_q >> 1;
    boundary_o = (len_q == '0) || (cnt_q == len_q - LEN_W'(1));
    bclk_o     = (len_q != '0) && (cnt_q < half);
    rise_o     = (len_q != '0) && (cnt_q == '0);
    len_o      = len_q;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      len_q <= '0;
    end else if (boundary_o) begin
      cnt_q <= '0;
      len_q <= len_next_i;
    end else begin
      cnt_q <= cnt_q + LEN_W'(1);
    end
  end

  // R1: the position never runs past the period length
  p_cnt_in_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (len_q != '0) |-> (cnt_q < len_q));
endmodule

// File: rtl/frac_bitclk_gen.sv
module frac_bitclk_gen
  import fbc_pkg::*;
#(
  parameter int A_W = 10,
  parameter int F_W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [A_W-1:0] div_int_i,
  input  logic [F_W-1:0] frac_num_i,
  input  logic [F_W-1:0] frac_den_i,
  input  logic           mode_plain_i,
  output logic           bclk_o,
  output logic           bclk_rise_o
);
  localparam int LEN_W = A_W + 1;

  logic             boundary;
  logic             stretch;
  logic             den_new;
  logic [A_W-1:0]   eff_a;
  logic [A_W-1:0]   a_q;
  logic [F_W:0]     num;
  logic [F_W:0]     den;
  logic [LEN_W-1:0] len_next;
  logic [LEN_W-1:0] len_cur;

  fbc_cfg_sample #(.A_W(A_W), .F_W(F_W)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (boundary),
    .a_i       (div_int_i),
    .b_i       (frac_num_i),
    .c_i       (frac_den_i),
    .mode_i    (mode_plain_i),
    .eff_a_o   (eff_a),
    .num_o     (num),
    .den_o     (den),
    .den_new_o (den_new),
    .a_q_o     (a_q)
  );

  fbc_phase_acc #(.F_W(F_W)) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (boundary),
    .clear_i   (den_new),
    .num_i     (num),
    .den_i     (den),
    .stretch_o (stretch)
  );

  assign len_next = LEN_W'(eff_a) + LEN_W'(stretch);

  fbc_period_gen #(.LEN_W(LEN_W)) u_per (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .len_next_i (len_next),
    .boundary_o (boundary),
    .len_o      (len_cur),
    .bclk_o     (bclk_o),
    .rise_o     (bclk_rise_o)
  );

  // R1: each period takes the sampled whole part or one more
  p_len_choice_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bclk_rise_o |-> ((len_cur == LEN_W'(a_q)) || (len_cur == LEN_W'(a_q) + LEN_W'(1))));
  // R6: strobe lasts one cycle and coincides with a high output
  p_rise_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bclk_rise_o |=> !bclk_rise_o);
  p_rise_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bclk_rise_o |-> bclk_o);
  // R5: the last cycle of every period is low
  p_low_at_end_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary && (len_cur != '0)) |-> !bclk_o);
endmodule

// File: tb/test_frac_bitclk_gen.sv
`timescale 1ns/1ps
module test_frac_bitclk_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] a_in = 10'd6;
  logic [7:0] b_in = 8'd0;
  logic [7:0] c_in = 8'd0;
  logic       plain = 1'b1;
  logic       bclk, rise;

  int n_chk = 0;
  int n_err = 0;
  bit cmp_en = 1'b0;

  always #2 clk = ~clk;

  frac_bitclk_gen i_frac_bitclk_gen (
    .clk_i(clk), .rst_ni(rst_n), .div_int_i(a_in), .frac_num_i(b_in),
    .frac_den_i(c_in), .mode_plain_i(plain), .bclk_o(bclk), .bclk_rise_o(rise));

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference: period position, period length, residue, last denominator.
  int m_pos = 0, m_len = 0, m_acc = 0, m_den = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_pos = 0; m_len = 0; m_acc = 0; m_den = 0;
    end else if (m_len == 0 || m_pos == m_len - 1) begin
      int a, d, n, s;
      a = (a_in < 2) ? 2 : int'(a_in);
      d = int'(c_in) + 1;
      n = plain ? int'(b_in) : int'(b_in) + 1;
      if (n > d) n = d;
      if (d != m_den) m_acc = 0;
      m_den = d;
      s = m_acc + n;
      if (s >= d) begin m_len = a + 1; m_acc = s - d; end
      else        begin m_len = a;     m_acc = s;     end
      m_pos = 0;
    end else begin
      m_pos++;
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      check("R1 R5 R6 R10 model bclk", int'(bclk), (m_len != 0 && m_pos < m_len / 2) ? 1 : 0);
      check("R6 R8 model rise", int'(rise), (m_len != 0 && m_pos == 0) ? 1 : 0);
    end
  end

  task automatic next_rise();
    do @(negedge clk); while (!rise);
  endtask

  // Called right at a rise sample; returns the length and high time of that period.
  task automatic one_period(output int len, output int hi);
    len = 0; hi = 0;
    do begin
      if (bclk) hi++;
      @(negedge clk);
      len++;
    end while (!rise);
  endtask

  task automatic set_cfg(input int a, input int b, input int c, input bit p);
    a_in = 10'(a); b_in = 8'(b); c_in = 8'(c); plain = p;
  endtask

  task automatic measure(input int a, input int b, input int c, input bit p, input string tag);
    int total, bad, aeff, n, len, hi;
    set_cfg(a, b, c, p);
    next_rise();
    next_rise();
    aeff = (a < 2) ? 2 : a;
    n = p ? b : b + 1;
    if (n > c + 1) n = c + 1;
    total = 0; bad = 0;
    for (int k = 0; k <= c; k++) begin
      one_period(len, hi);
      total += len;
      if (len != aeff && len != aeff + 1) bad++;
    end
    check({tag, " total"}, total, (c + 1) * aeff + n);
    check("R1 period outside {A,A+1}", bad, 0);
  endtask

  initial begin
    int len, hi, l2;
    repeat (5) @(negedge clk);
    cmp_en = 1'b1;
    check("R8 bclk in reset", int'(bclk), 0);
    check("R8 rise in reset", int'(rise), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 first rise after release", int'(rise), 1);
    @(negedge clk);
    check("R6 rise one cycle", int'(rise), 0);

    measure(3, 0, 0, 1'b0, "R2 A=3 B=0 C=0");
    measure(5, 2, 6, 1'b0, "R2 A=5 B=2 C=6");
    measure(5, 2, 6, 1'b1, "R3 A=5 B=2 C=6");
    measure(9, 0, 6, 1'b1, "R3 zero numerator");
    measure(12, 255, 255, 1'b1, "R3 full fraction");
    measure(1000, 7, 15, 1'b0, "R2 large whole part");
    measure(4, 20, 5, 1'b0, "R4 saturated numerator");

    // R4: every period stretched when saturated
    next_rise(); one_period(len, hi);
    check("R4 saturated period", len, 5);

    // R9: whole part below minimum
    measure(0, 0, 1, 1'b1, "R9 A=0 clamp");
    next_rise(); one_period(len, hi);
    check("R9 clamped period", len, 2);
    check("R5 high time len 2", hi, 1);

    // R5: odd period length
    set_cfg(7, 0, 0, 1'b1);
    next_rise(); next_rise(); one_period(len, hi);
    check("R5 period len 7", len, 7);
    check("R5 high time len 7", hi, 3);

    // R7: mid-period change of A
    set_cfg(20, 0, 0, 1'b1);
    next_rise(); next_rise();
    repeat (3) @(negedge clk);
    a_in = 10'd7;
    len = 3;
    do begin @(negedge clk); len++; end while (!rise);
    check("R7 period after mid change", len, 20);
    one_period(l2, hi);
    check("R7 next period uses new A", l2, 7);

    // R10: denominator change clears the residue
    set_cfg(4, 0, 3, 1'b0);
    next_rise(); next_rise();
    one_period(len, hi);
    while (len != 5) one_period(len, hi);
    // Residue is now 0; three short periods bring it to 3.
    one_period(len, hi); check("R10 build-up period 1", len, 4);
    one_period(len, hi); check("R10 build-up period 2", len, 4);
    c_in = 8'd1;
    one_period(len, hi); check("R10 build-up period 3", len, 4);
    one_period(len, hi); check("R10 after C change", len, 4);
    one_period(len, hi); check("R10 second after C change", len, 5);

    cmp_en = 1'b0;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule